// File: doc/BRIEF.md
# Effective address and operand fetch unit

This unit turns one operand reference into a value. A caller presents a 4-bit mode code, an address field, a register selector and a nesting level, and pulses `start`. The unit reads the named register through a combinational register file port, computes the effective address from the address field, the register, the latched program counter or its own stack pointer, and issues as many memory reads as the mode needs. When the operand is in hand it returns the operand and the effective address with a one-cycle `done` pulse.

Memory is reached through a request/valid read port with one read outstanding at a time. The response may arrive any number of cycles after the request. Pointer-chasing modes reuse the same port once per hop. The indexed auto-increment mode writes the incremented index back through a register write port. The stack mode pops: it reads at the stack pointer and then moves the pointer up by one, so the stack grows toward lower addresses. All address arithmetic wraps modulo 2^DW.

Top module: `ea_operand_unit`

## Requirements
- R1: Mode 0 (immediate) returns operand = A and ea = A with no memory request, and `done` is high in the second clock cycle after the `start` cycle.
- R2: Mode 1 (direct) returns ea = A and operand = mem[A] after exactly one memory read.
- R3: Mode 2 (nested indirect) with level L in 1..3 follows L pointers starting at A. ea is the last pointer, operand = mem[ea], and L+1 reads are made. L = 0 raises `err` and makes no read.
- R4: Mode 3 (register) returns operand = reg[R] and ea = R zero-extended, with no read. Mode 4 (register indirect) returns ea = reg[R] and operand = mem[ea] after one read.
- R5: Mode 5 (displacement) uses ea = A + reg[R]. Mode 6 (relative) uses ea = A + PC, with PC sampled at `start`. Each makes one read, and the sum wraps modulo 2^DW.
- R6: Mode 7 (indexed, auto-increment) uses ea = A + reg[R] and makes one read. In the `done` cycle it asserts `rf_we` with `rf_waddr` = R and `rf_wdata` = reg[R] + 1 (wrapping). No other mode asserts `rf_we`.
- R7: Mode 8 (post-indexed) reads mem[A] and then uses ea = mem[A] + reg[R]. It makes two reads.
- R8: Mode 9 (pre-indexed) reads mem[A + reg[R]] and uses that value as ea. It makes two reads.
- R9: Mode 10 (stack pop) uses ea = SP and operand = mem[SP]. SP then becomes SP + 1 (wrapping). Reset loads SP with SP_INIT, and SP changes in no other case.
- R10: Mode codes 11 to 15 raise a one-cycle `err` instead of `done`. They make no memory read, leave SP unchanged and do not make the unit busy.
- R11: At most one memory read is outstanding at a time. The unit waits for `mem_valid` however long it takes. A `start` while `busy` is high is ignored.
- R12: `done` and `err` are single-cycle pulses and are never high together. After `done`, `busy` is low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin resolving one operand (accepted when not busy) |
| mode | input | 4 | Addressing mode code |
| a_field | input | DW | Address field from the instruction |
| reg_sel | input | RW | Register selector |
| level | input | 2 | Indirection depth for the nested mode |
| pc_in | input | DW | Current program counter |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Result valid pulse |
| err | output | 1 | Illegal mode or level pulse |
| ea | output | DW | Effective address of the finished operation |
| operand | output | DW | Operand value of the finished operation |
| rf_raddr | output | RW | Register file read address |
| rf_rdata | input | DW | Register file read data (combinational) |
| rf_we | output | 1 | Register write strobe for auto-increment |
| rf_waddr | output | RW | Register write address |
| rf_wdata | output | DW | Register write data |
| mem_req | output | 1 | Memory read request pulse |
| mem_addr | output | DW | Memory read address |
| mem_valid | input | 1 | Memory read data valid |
| mem_rdata | input | DW | Memory read data |
| sp | output | DW | Stack pointer |

## Verification
The hardest case to reach is a `start` pulse carrying a different mode that arrives while a three-level indirect chain is still waiting on memory. The stimulus holds that chain open with random response delays of one to three cycles per read, and raises a stray immediate-mode `start` two cycles in. Stack-pointer wrap is reached by resetting SP near the top of the address space and popping past it. The auto-increment wrap is reached by loading an index register with all ones. Random mode codes, which include the illegal ones, are mixed between these directed cases so that each mode starts from the idle state left by every other mode.

// File: rtl/ea_pkg.sv
package ea_pkg;

  typedef enum logic [3:0] {
    AM_IMM  = 4'd0,
    AM_DIR  = 4'd1,
    AM_IND  = 4'd2,
    AM_REG  = 4'd3,
    AM_RIND = 4'd4,
    AM_DISP = 4'd5,
    AM_REL  = 4'd6,
    AM_IDXI = 4'd7,
    AM_POST = 4'd8,
    AM_PRE  = 4'd9,
    AM_POP  = 4'd10
  } amode_e;

  localparam logic [3:0] AM_LAST = 4'd10;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CALC = 2'd1,
    ST_WAIT = 2'd2
  } fsm_e;

  function automatic logic mode_legal(input logic [3:0] m);
    return m <= AM_LAST;
  endfunction

endpackage

// File: rtl/ea_addr_gen.sv
module ea_addr_gen
  import ea_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic [3:0]    mode,
  input  logic [DW-1:0] a_fld,
  input  logic [DW-1:0] reg_val,
  input  logic [DW-1:0] pc_val,
  input  logic [DW-1:0] sp_val,
  output logic [DW-1:0] base
);

  // First address each memory-using mode sends out.
  always_comb begin
    case (mode)
      AM_RIND:                   base = reg_val;
      AM_DISP, AM_IDXI, AM_PRE:  base = a_fld + reg_val;
      AM_REL:                    base = a_fld + pc_val;
      AM_POP:                    base = sp_val;
      default:                   base = a_fld;
    endcase
  end

endmodule

// File: rtl/ea_mem_port.sv
module ea_mem_port #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic [DW-1:0] go_addr,
  output logic          mem_req,
  output logic [DW-1:0] mem_addr,
  input  logic          mem_valid,
  input  logic [DW-1:0] mem_rdata,
  output logic          resp_vld,
  output logic [DW-1:0] resp_data
);

  logic          req_q;
  logic          pend_q;
  logic [DW-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q  <= 1'b0;
      pend_q <= 1'b0;
      addr_q <= '0;
    end else begin
      req_q <= go;
      if (go) begin
        addr_q <= go_addr;
        pend_q <= 1'b1;
      end else if (mem_valid && pend_q) begin
        pend_q <= 1'b0;
      end
    end
  end

  assign mem_req   = req_q;
  assign mem_addr  = addr_q;
  assign resp_vld  = mem_valid && pend_q;
  assign resp_data = mem_rdata;

  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (rst)
    go |-> (!pend_q || resp_vld)); // R11

  AST_REQ_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
    (pend_q && !go) |=> $stable(mem_addr)); // R11

endmodule

// File: rtl/ea_stack_ptr.sv
module ea_stack_ptr #(
  parameter int          DW      = 16,
  parameter int unsigned SP_INIT = 32'h0000_FFFE
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pop,
  output logic [DW-1:0] sp
);

  localparam logic [DW-1:0] SP_RST = DW'(SP_INIT);

  logic [DW-1:0] sp_q;

  always_ff @(posedge clk) begin
    if (rst)      sp_q <= SP_RST;
    else if (pop) sp_q <= sp_q + DW'(1);
  end

  assign sp = sp_q;

  AST_SP_HOLD: assert property (@(posedge clk) disable iff (rst)
    !pop |=> $stable(sp_q)); // R9

  AST_SP_STEP: assert property (@(posedge clk) disable iff (rst)
    pop |=> (sp_q == $past(sp_q) + DW'(1))); // R9

endmodule

// File: rtl/ea_operand_unit.sv
module ea_operand_unit
  import ea_pkg::*;
#(
  parameter int          DW      = 16,
  parameter int          RW      = 3,
  parameter int unsigned SP_INIT = 32'h0000_FFFE
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [3:0]    mode,
  input  logic [DW-1:0] a_field,
  input  logic [RW-1:0] reg_sel,
  input  logic [1:0]    level,
  input  logic [DW-1:0] pc_in,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic [DW-1:0] ea,
  output logic [DW-1:0] operand,
  output logic [RW-1:0] rf_raddr,
  input  logic [DW-1:0] rf_rdata,
  output logic          rf_we,
  output logic [RW-1:0] rf_waddr,
  output logic [DW-1:0] rf_wdata,
  output logic          mem_req,
  output logic [DW-1:0] mem_addr,
  input  logic          mem_valid,
  input  logic [DW-1:0] mem_rdata,
  output logic [DW-1:0] sp
);

  fsm_e          state_q;
  logic [3:0]    mode_q;
  logic [DW-1:0] a_q;
  logic [RW-1:0] r_q;
  logic [1:0]    lvl_q;
  logic [DW-1:0] pc_q;
  logic [DW-1:0] rv_q;
  logic [DW-1:0] cur_q;
  logic [1:0]    hops_q;
  logic [DW-1:0] op_q;
  logic [DW-1:0] ea_q;
  logic          done_q;
  logic          err_q;
  logic          wb_q;
  logic [DW-1:0] wbd_q;

  logic [DW-1:0] base;
  logic          go;
  logic [DW-1:0] go_addr;
  logic          resp_vld;
  logic [DW-1:0] resp_data;
  logic [DW-1:0] hop_addr;
  logic          no_mem;
  logic          last_rd;
  logic          pop;

  ea_addr_gen #(.DW(DW)) u_agen (
    .mode    (mode_q),
    .a_fld   (a_q),
    .reg_val (rf_rdata),
    .pc_val  (pc_q),
    .sp_val  (sp),
    .base    (base)
  );

  ea_mem_port #(.DW(DW)) u_port (
    .clk       (clk),
    .rst       (rst),
    .go        (go),
    .go_addr   (go_addr),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr),
    .mem_valid (mem_valid),
    .mem_rdata (mem_rdata),
    .resp_vld  (resp_vld),
    .resp_data (resp_data)
  );

  ea_stack_ptr #(.DW(DW), .SP_INIT(SP_INIT)) u_sp (
    .clk (clk),
    .rst (rst),
    .pop (pop),
    .sp  (sp)
  );

  // Combinational steering between the sequencer and the read port
  assign no_mem   = (mode_q == AM_IMM) || (mode_q == AM_REG);
  assign hop_addr = resp_data + ((mode_q == AM_POST) ? rv_q : '0);
  assign last_rd  = (state_q == ST_WAIT) && resp_vld && (hops_q == 2'd0);
  assign pop      = last_rd && (mode_q == AM_POP);
  assign go       = ((state_q == ST_CALC) && !no_mem) ||
                    ((state_q == ST_WAIT) && resp_vld && (hops_q != 2'd0));
  assign go_addr  = (state_q == ST_CALC) ? base : hop_addr;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      mode_q  <= '0;
      a_q     <= '0;
      r_q     <= '0;
      lvl_q   <= '0;
      pc_q    <= '0;
      rv_q    <= '0;
      cur_q   <= '0;
      hops_q  <= '0;
      op_q    <= '0;
      ea_q    <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      wb_q    <= 1'b0;
      wbd_q   <= '0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      wb_q   <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            if (!mode_legal(mode) || ((mode == AM_IND) && (level == 2'd0))) begin
              err_q <= 1'b1;
            end else begin
              mode_q  <= mode;
              a_q     <= a_field;
              r_q     <= reg_sel;
              lvl_q   <= level;
              pc_q    <= pc_in;
              state_q <= ST_CALC;
            end
          end
        end
        ST_CALC: begin
          rv_q <= rf_rdata;
          if (mode_q == AM_IMM) begin
            op_q    <= a_q;
            ea_q    <= a_q;
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else if (mode_q == AM_REG) begin
            op_q    <= rf_rdata;
            ea_q    <= DW'(r_q);
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            cur_q <= base;
            if (mode_q == AM_IND)                            hops_q <= lvl_q;
            else if ((mode_q == AM_POST) || (mode_q == AM_PRE)) hops_q <= 2'd1;
            else                                              hops_q <= 2'd0;
            state_q <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (resp_vld) begin
            if (hops_q != 2'd0) begin
              hops_q <= hops_q - 2'd1;
              cur_q  <= hop_addr;
            end else begin
              op_q    <= resp_data;
              ea_q    <= cur_q;
              done_q  <= 1'b1;
              state_q <= ST_IDLE;
              if (mode_q == AM_IDXI) begin
                wb_q  <= 1'b1;
                wbd_q <= rv_q + DW'(1);
              end
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy     = (state_q != ST_IDLE);
  assign done     = done_q;
  assign err      = err_q;
  assign ea       = ea_q;
  assign operand  = op_q;
  assign rf_raddr = r_q;
  assign rf_we    = wb_q;
  assign rf_waddr = r_q;
  assign rf_wdata = wbd_q;

  AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(done_q && err_q)); // R12

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done_q |=> (!done_q && !busy)); // R12

  AST_FAST_MODES: assert property (@(posedge clk) disable iff (rst)
    ((state_q == ST_CALC) && no_mem) |=> (done_q && !mem_req)); // R1

  AST_WB_ONLY_IDX: assert property (@(posedge clk) disable iff (rst)
    rf_we |-> (done_q && (mode_q == AM_IDXI))); // R6

  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (rst)
    err_q |-> (!busy && !mem_req)); // R10

  AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (rst)
    ((state_q == ST_IDLE) && !$past(go)) |-> !mem_req); // R11

endmodule

// File: tb/ea_operand_unit_tb.sv
`timescale 1ns/1ps
module ea_operand_unit_tb;

  localparam int DW = 16;
  localparam int RW = 3;
  localparam logic [15:0] SP0 = 16'hFFFE;

  logic          clk = 1'b0;
  logic          rst;
  logic          start;
  logic [3:0]    mode_i;
  logic [DW-1:0] a_i;
  logic [RW-1:0] r_i;
  logic [1:0]    lvl_i;
  logic [DW-1:0] pc_i;
  logic          busy, done, err;
  logic [DW-1:0] ea, operand;
  logic [RW-1:0] rf_raddr, rf_waddr;
  logic [DW-1:0] rf_rdata, rf_wdata;
  logic          rf_we;
  logic          mem_req;
  logic [DW-1:0] mem_addr;
  logic          mem_valid = 1'b0;
  logic [DW-1:0] mem_rdata = '0;
  logic [DW-1:0] sp;

  logic [DW-1:0] regs [8];
  int            n_checks = 0;
  int            n_err    = 0;
  int            req_total = 0;
  logic [DW-1:0] exp_sp;

  always #10 clk = ~clk;

  ea_operand_unit #(.DW(DW), .RW(RW), .SP_INIT(32'(SP0))) u_dut (
    .clk(clk), .rst(rst), .start(start), .mode(mode_i), .a_field(a_i),
    .reg_sel(r_i), .level(lvl_i), .pc_in(pc_i), .busy(busy), .done(done),
    .err(err), .ea(ea), .operand(operand), .rf_raddr(rf_raddr),
    .rf_rdata(rf_rdata), .rf_we(rf_we), .rf_waddr(rf_waddr),
    .rf_wdata(rf_wdata), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_valid(mem_valid), .mem_rdata(mem_rdata), .sp(sp)
  );

  assign rf_rdata = regs[rf_raddr];

  function automatic logic [15:0] memf(input logic [15:0] ad);
    logic [31:0] t;
    t = {16'h0, ad} * 32'd40503 + 32'd777;
    return t[15:0] ^ t[31:16];
  endfunction

  // Memory responder: random 1..3 cycle latency, one read at a time
  int            lat = 0;
  logic          pend = 1'b0;
  logic [DW-1:0] paddr = '0;
  always @(negedge clk) begin
    mem_valid <= 1'b0;
    if (mem_req) begin
      req_total <= req_total + 1;
      lat       <= 1 + int'($urandom % 3);
      pend      <= 1'b1;
      paddr     <= mem_addr;
    end else if (pend) begin
      if (lat == 1) begin
        mem_valid <= 1'b1;
        mem_rdata <= memf(paddr);
        pend      <= 1'b0;
      end else begin
        lat <= lat - 1;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  function automatic string tag_of(input logic [3:0] m);
    case (m)
      4'd0: return "R1";
      4'd1: return "R2";
      4'd2: return "R3";
      4'd3, 4'd4: return "R4";
      4'd5, 4'd6: return "R5";
      4'd7: return "R6";
      4'd8: return "R7";
      4'd9: return "R8";
      4'd10: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic run_op(input logic [3:0] m, input logic [15:0] a, input logic [2:0] r,
                        input logic [1:0] lv, input logic [15:0] pcv, input bit poke);
    bit e_err, e_wb;
    logic [15:0] e_ea, e_op, e_wbd, rv, p;
    int e_reads, base, cyc;
    string tg;
    tg = tag_of(m);
    rv = regs[r];
    e_err = 1'b0; e_wb = 1'b0; e_wbd = '0; e_ea = '0; e_op = '0; e_reads = 0;
    case (m)
      4'd0: begin e_ea = a; e_op = a; end
      4'd1: begin e_ea = a; e_reads = 1; end
      4'd2: begin
        if (lv == 2'd0) e_err = 1'b1;
        else begin
          p = a;
          for (int k = 0; k < int'(lv); k++) p = memf(p);
          e_ea = p; e_reads = int'(lv) + 1;
        end
      end
      4'd3: begin e_ea = 16'(r); e_op = rv; end
      4'd4: begin e_ea = rv; e_reads = 1; end
      4'd5: begin e_ea = a + rv; e_reads = 1; end
      4'd6: begin e_ea = a + pcv; e_reads = 1; end
      4'd7: begin e_ea = a + rv; e_reads = 1; e_wb = 1'b1; e_wbd = rv + 16'd1; end
      4'd8: begin e_ea = memf(a) + rv; e_reads = 2; end
      4'd9: begin e_ea = memf(a + rv); e_reads = 2; end
      4'd10: begin e_ea = exp_sp; e_reads = 1; end
      default: e_err = 1'b1;
    endcase
    if (!e_err && e_reads > 0) e_op = memf(e_ea);
    base = req_total;
    mode_i = m; a_i = a; r_i = r; lvl_i = lv; pc_i = pcv; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (!(done || err) && cyc < 200) begin
      @(negedge clk);
      cyc++;
      if (poke && cyc == 2) begin start = 1'b1; mode_i = 4'd0; a_i = 16'hDEAD; end
      if (poke && cyc == 3) begin start = 1'b0; mode_i = m; a_i = a; end
    end
    if (cyc >= 200) chk(1'b0, tg, 32'(cyc), 32'd0);
    if (e_err) begin
      chk(err && !done, tg, {30'd0, err, done}, 32'd2);
      chk(req_total == base, "R10", 32'(req_total - base), 32'd0);
    end else begin
      chk(done && !err, tg, {30'd0, err, done}, 32'd1);
      chk(operand == e_op, tg, 32'(operand), 32'(e_op));
      chk(ea == e_ea, tg, 32'(ea), 32'(e_ea));
      chk(req_total - base == e_reads, tg, 32'(req_total - base), 32'(e_reads));
      chk(rf_we == e_wb, "R6", 32'(rf_we), 32'(e_wb));
      if (e_wb) begin
        chk(rf_waddr == r && rf_wdata == e_wbd, "R6", 32'(rf_wdata), 32'(e_wbd));
      end
      if (rf_we) regs[rf_waddr] = rf_wdata;
      if (m == 4'd0 || m == 4'd3) chk(cyc == 1, "R1", 32'(cyc), 32'd1);
      if (m == 4'd10) exp_sp = exp_sp + 16'd1;
      if (poke) chk(operand == e_op && ea == e_ea, "R11", 32'(operand), 32'(e_op));
    end
    @(negedge clk);
    chk(!done && !err && !busy, "R12", {29'd0, busy, err, done}, 32'd0);
    chk(sp == exp_sp, "R9", 32'(sp), 32'(exp_sp));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    $display("FAIL R11 watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err + 1, n_checks + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'd31337));
    for (int i = 0; i < 8; i++) regs[i] = 16'(i * 16'h1111 + 3);
    rst = 1'b1; start = 1'b0; mode_i = '0; a_i = '0; r_i = '0; lvl_i = '0; pc_i = '0;
    exp_sp = SP0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!done && !err && !busy && !mem_req, "R12", {28'd0, mem_req, busy, err, done}, 32'd0);
    chk(sp == SP0, "R9", 32'(sp), 32'(SP0));

    // Directed corner cases
    run_op(4'd0, 16'h1234, 3'd0, 2'd0, 16'h0, 1'b0);      // R1
    run_op(4'd1, 16'h0040, 3'd0, 2'd0, 16'h0, 1'b0);      // R2
    run_op(4'd2, 16'h0100, 3'd0, 2'd1, 16'h0, 1'b0);      // R3 one level
    run_op(4'd2, 16'h0200, 3'd0, 2'd2, 16'h0, 1'b0);      // R3 two levels
    run_op(4'd2, 16'h0300, 3'd0, 2'd3, 16'h0, 1'b0);      // R3 three levels
    run_op(4'd2, 16'h0300, 3'd0, 2'd0, 16'h0, 1'b0);      // R3 level 0 is an error
    run_op(4'd3, 16'h0000, 3'd5, 2'd0, 16'h0, 1'b0);      // R4 register
    run_op(4'd4, 16'h0000, 3'd2, 2'd0, 16'h0, 1'b0);      // R4 register indirect
    regs[1] = 16'h0002;
    run_op(4'd5, 16'hFFFF, 3'd1, 2'd0, 16'h0, 1'b0);      // R5 wrap
    run_op(4'd6, 16'hFFF0, 3'd0, 2'd0, 16'h0020, 1'b0);   // R5 relative wrap
    regs[7] = 16'hFFFF;
    run_op(4'd7, 16'h0010, 3'd7, 2'd0, 16'h0, 1'b0);      // R6 increment wraps to 0
    run_op(4'd7, 16'h0010, 3'd7, 2'd0, 16'h0, 1'b0);      // R6 again from 0
    run_op(4'd8, 16'h0400, 3'd3, 2'd0, 16'h0, 1'b0);      // R7
    run_op(4'd9, 16'h0500, 3'd4, 2'd0, 16'h0, 1'b0);      // R8
    run_op(4'd10, 16'h0000, 3'd0, 2'd0, 16'h0, 1'b0);     // R9 pop at FFFE
    run_op(4'd10, 16'h0000, 3'd0, 2'd0, 16'h0, 1'b0);     // R9 pop at FFFF, SP wraps
    run_op(4'd11, 16'h0000, 3'd0, 2'd0, 16'h0, 1'b0);     // R10
    run_op(4'd15, 16'h0000, 3'd0, 2'd0, 16'h0, 1'b0);     // R10
    run_op(4'd2, 16'h0700, 3'd0, 2'd3, 16'h0, 1'b1);      // R11 start while busy

    // Constrained random mix
    for (int n = 0; n < 400; n++) begin
      if ($urandom % 8 == 0) regs[$urandom % 8] = 16'($urandom);
      run_op(4'($urandom % 16), 16'($urandom), 3'($urandom % 8), 2'($urandom % 4),
             16'($urandom), ($urandom % 16) == 0);
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

endmodule